// File: doc/BRIEF.md
# Receive Free-Buffer Ring Allocator

This block hands a host buffer to each new packet arriving on a receive channel. The packet's virtual channel identifier (VCI) selects the channel directly. Each channel carries one configuration bit that picks one of two shared free-buffer rings: one for small buffers, one for big buffers. The host fills both rings ahead of time, so a channel never asks for memory while it runs.

On a start of packet, the block reads the head entry of the chosen ring through a simple request/response port. If the host has handed that entry to the device, the block returns the entry's buffer pointer, gives the entry back to the host and moves that ring's head forward, wrapping at the ring depth. If the entry is still held by the host, the block reports that no buffer was available and drops the packet start rather than waiting.

A VCI of zero is the maintenance (OAM) path and goes to a separate output. A VCI past the last channel is flagged invalid. Neither touches the rings. Head indices are kept in internal registers, apart from the channel table.

Top module: `rx_fbuf_alloc`

## Requirements
- R1: After reset, `sop_ready` is 1, all result pulses and `mem_req`/`mem_clr` are 0, and both ring heads are at index 0.
- R2: A channel whose selector bit (written through `cfg_we`/`cfg_ch`/`cfg_big`) is 0 reads the small ring (`mem_ring`=0). A channel whose bit is 1 reads the big ring (`mem_ring`=1). All bits reset to 0.
- R3: A data start of packet (1 <= VCI <= NUM_CH-1) issues `mem_req` in the cycle after acceptance, at the current head of the chosen ring. When the response has the ownership bit set (`mem_own`=1, device-owned), `alloc_valid` pulses one cycle later with `alloc_ptr` = `mem_ptr`, `alloc_big` = ring and `alloc_ch` = VCI.
- R4: In the same cycle as `alloc_valid`, `mem_clr` pulses with `mem_ring`/`mem_idx` naming the consumed entry, which returns its ownership to the host.
- R5: Each ring head advances by one only on a successful allocation from that ring. It wraps from RING_DEPTH-1 to 0, and the two rings advance independently.
- R6: When the response has `mem_own`=0, `nobuf` pulses one cycle later with `alloc_ch` = VCI. No `mem_clr` is issued and the head does not move.
- R7: A start of packet with VCI 0 pulses `oam_valid` in the next cycle. It issues no `mem_req` and moves no head.
- R8: A start of packet with VCI >= NUM_CH (above 1023 by default) pulses `bad_vci` in the next cycle. It issues no `mem_req` and moves no head.
- R9: Only one lookup is outstanding. `sop_ready` is 0 from the cycle after a data acceptance until the result pulse, and `sop_valid` is ignored while `sop_ready` is 0.
- R10: Each accepted start of packet produces exactly one of `alloc_valid`, `nobuf`, `oam_valid`, `bad_vci`, and these never pulse together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write a channel's ring selector bit |
| cfg_ch | input | CH_W (10) | Channel whose bit is written |
| cfg_big | input | 1 | Selector value: 1 big ring, 0 small ring |
| sop_valid | input | 1 | Start of packet present |
| sop_vci | input | VCI_W (12) | VCI of the starting packet |
| sop_ready | output | 1 | Block can accept a start of packet |
| mem_req | output | 1 | Ring entry read request (one-cycle pulse) |
| mem_ring | output | 1 | Ring addressed: 0 small, 1 big |
| mem_idx | output | RING_AW (3) | Entry index within the ring |
| mem_rvalid | input | 1 | Read response valid |
| mem_own | input | 1 | Entry ownership: 1 device, 0 host |
| mem_ptr | input | PTR_W (32) | Buffer pointer held in the entry |
| mem_clr | output | 1 | Return the entry at `mem_ring`/`mem_idx` to the host |
| alloc_valid | output | 1 | Buffer assigned (pulse) |
| alloc_ptr | output | PTR_W (32) | Assigned buffer pointer |
| alloc_big | output | 1 | Assigned buffer came from the big ring |
| alloc_ch | output | CH_W (10) | Channel of the last data lookup |
| nobuf | output | 1 | Head entry not device-owned, packet start dropped (pulse) |
| oam_valid | output | 1 | Maintenance-path start of packet (pulse) |
| bad_vci | output | 1 | VCI outside the channel range (pulse) |

## Verification
Data starts on small-ring and big-ring channels are interleaved, so a swapped selector or shared head shows up as a wrong pointer. A start on VCI 0 and on out-of-range VCIs is placed between data starts, and the next allocation's pointer shows whether those starts disturbed a head. A host-owned head entry is placed once mid-ring, then refilled, which separates "drop without advance" from "skip the entry". Eight small allocations followed by a ninth show the wrap onto an already-returned entry. A start of packet is also driven while a lookup is pending, to show that it is ignored.

// File: rtl/rxfb_pkg.sv
// Package: shared types for the receive free-buffer allocator.
// Assumes two rings, indexed by the per-channel selector bit.
package rxfb_pkg;
    localparam int NUM_RINGS = 2;

    typedef enum logic [1:0] {
        VC_DATA = 2'd0,
        VC_OAM  = 2'd1,
        VC_BAD  = 2'd2
    } vci_class_e;
endpackage

// File: rtl/rxfb_vci_steer.sv
// Module: classifies an incoming VCI as data channel, maintenance, or invalid.
// Assumes VCI_W >= CH_W and that VCI 0 is reserved for maintenance cells.
module rxfb_vci_steer
    import rxfb_pkg::*;
#(
    parameter int VCI_W  = 12,
    parameter int NUM_CH = 1024,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic [VCI_W-1:0] vci,
    output vci_class_e       cls,
    output logic [CH_W-1:0]  ch
);
    localparam logic [VCI_W:0] LIMIT = (VCI_W+1)'(NUM_CH);

    // Decide which path the VCI is steered to.
    always_comb begin
        if (vci == '0)                 cls = VC_OAM;
        else if ({1'b0, vci} >= LIMIT) cls = VC_BAD;
        else                           cls = VC_DATA;
    end

    assign ch = vci[CH_W-1:0];
endmodule

// File: rtl/rxfb_chan_table.sv
// Module: per-channel ring selector bits (0 small ring, 1 big ring).
// Assumes a single write port and a combinational read of one channel.
module rxfb_chan_table #(
    parameter int NUM_CH = 1024,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [CH_W-1:0] wr_ch,
    input  logic            wr_big,
    input  logic [CH_W-1:0] rd_ch,
    output logic            rd_big
);
    logic [NUM_CH-1:0] sel_q;

    // Hold the selector bits; all channels start on the small ring.
    always_ff @(posedge clk) begin
        if (!rst_n)     sel_q <= '0;
        else if (wr_en) sel_q[wr_ch] <= wr_big;
    end

    assign rd_big = sel_q[rd_ch];
endmodule

// File: rtl/rxfb_ring_heads.sv
// Module: head index register of each free-buffer ring.
// Assumes at most one ring advances per cycle; wraps at RING_DEPTH.
module rxfb_ring_heads
    import rxfb_pkg::*;
#(
    parameter int RING_DEPTH = 8,
    parameter int RING_AW    = $clog2(RING_DEPTH)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                adv,
    input  logic                                adv_ring,
    output logic [NUM_RINGS-1:0][RING_AW-1:0]   head
);
    localparam logic [RING_AW-1:0] LAST = RING_AW'(RING_DEPTH - 1);

    for (genvar r = 0; r < NUM_RINGS; r++) begin : g_ring
        // Advance this ring's head on a consume, wrapping at the last entry.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                head[r] <= '0;
            end else if (adv && (adv_ring == 1'(r))) begin
                head[r] <= (head[r] == LAST) ? '0 : head[r] + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rxfb_alloc_fsm.sv
// Module: sequences one lookup per start of packet and reports its outcome.
// Assumes the memory answers each mem_req with exactly one mem_rvalid.
module rxfb_alloc_fsm
    import rxfb_pkg::*;
#(
    parameter int CH_W    = 10,
    parameter int RING_AW = 3,
    parameter int PTR_W   = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               sop_valid,
    input  vci_class_e                         cls,
    input  logic [CH_W-1:0]                    ch,
    input  logic                               ch_big,
    input  logic [NUM_RINGS-1:0][RING_AW-1:0]  head,
    output logic                               sop_ready,
    output logic                               mem_req,
    output logic                               mem_ring,
    output logic [RING_AW-1:0]                 mem_idx,
    input  logic                               mem_rvalid,
    input  logic                               mem_own,
    input  logic [PTR_W-1:0]                   mem_ptr,
    output logic                               mem_clr,
    output logic                               adv,
    output logic                               alloc_valid,
    output logic [PTR_W-1:0]                   alloc_ptr,
    output logic [CH_W-1:0]                    alloc_ch,
    output logic                               nobuf,
    output logic                               oam_valid,
    output logic                               bad_vci
);
    typedef enum logic {ST_IDLE, ST_WAIT} state_e;
    state_e state;

    logic take;
    assign sop_ready = (state == ST_IDLE);
    assign take      = (state == ST_WAIT) && mem_rvalid;
    assign adv       = take && mem_own;

    // Accept a start of packet, issue the read, and turn the reply into one result pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            mem_req     <= 1'b0;
            mem_ring    <= 1'b0;
            mem_idx     <= '0;
            mem_clr     <= 1'b0;
            alloc_valid <= 1'b0;
            alloc_ptr   <= '0;
            alloc_ch    <= '0;
            nobuf       <= 1'b0;
            oam_valid   <= 1'b0;
            bad_vci     <= 1'b0;
        end else begin
            mem_req     <= 1'b0;
            mem_clr     <= 1'b0;
            alloc_valid <= 1'b0;
            nobuf       <= 1'b0;
            oam_valid   <= 1'b0;
            bad_vci     <= 1'b0;
            if (state == ST_IDLE) begin
                if (sop_valid) begin
                    case (cls)
                        VC_OAM:  oam_valid <= 1'b1;
                        VC_BAD:  bad_vci   <= 1'b1;
                        default: begin
                            mem_req  <= 1'b1;
                            mem_ring <= ch_big;
                            mem_idx  <= head[ch_big];
                            alloc_ch <= ch;
                            state    <= ST_WAIT;
                        end
                    endcase
                end
            end else if (take) begin
                state <= ST_IDLE;
                if (mem_own) begin
                    alloc_valid <= 1'b1;
                    alloc_ptr   <= mem_ptr;
                    mem_clr     <= 1'b1;
                end else begin
                    nobuf <= 1'b1;
                end
            end
        end
    end

    AST_OAM_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (sop_ready && sop_valid && cls == VC_OAM) |=> (oam_valid && !mem_req)); // R7
    AST_BAD_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (sop_ready && sop_valid && cls == VC_BAD) |=> (bad_vci && !mem_req)); // R8
    AST_HOST_OWNED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !mem_own) |=> (nobuf && !mem_clr && !alloc_valid)); // R6
    AST_OWNED_RETURNED: assert property (@(posedge clk) disable iff (!rst_n)
        (take && mem_own) |=> (alloc_valid && mem_clr && alloc_ptr == $past(mem_ptr))); // R4
    AST_SINGLE_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !sop_ready); // R9
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({alloc_valid, nobuf, oam_valid, bad_vci})); // R10
endmodule

// File: rtl/rx_fbuf_alloc.sv
// Module: top of the receive free-buffer allocator. Routes a start of packet by
// VCI, picks a ring from the channel table, and takes that ring's head entry.
// Assumes the host refills ring entries and sets their ownership bits itself.
module rx_fbuf_alloc
    import rxfb_pkg::*;
#(
    parameter int VCI_W      = 12,
    parameter int NUM_CH     = 1024,
    parameter int RING_DEPTH = 8,
    parameter int PTR_W      = 32,
    localparam int CH_W      = $clog2(NUM_CH),
    localparam int RING_AW   = $clog2(RING_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CH_W-1:0]    cfg_ch,
    input  logic               cfg_big,
    input  logic               sop_valid,
    input  logic [VCI_W-1:0]   sop_vci,
    output logic               sop_ready,
    output logic               mem_req,
    output logic               mem_ring,
    output logic [RING_AW-1:0] mem_idx,
    input  logic               mem_rvalid,
    input  logic               mem_own,
    input  logic [PTR_W-1:0]   mem_ptr,
    output logic               mem_clr,
    output logic               alloc_valid,
    output logic [PTR_W-1:0]   alloc_ptr,
    output logic               alloc_big,
    output logic [CH_W-1:0]    alloc_ch,
    output logic               nobuf,
    output logic               oam_valid,
    output logic               bad_vci
);
    vci_class_e                        cls;
    logic [CH_W-1:0]                   ch;
    logic                              ch_big;
    logic                              adv;
    logic [NUM_RINGS-1:0][RING_AW-1:0] head;

    rxfb_vci_steer #(.VCI_W(VCI_W), .NUM_CH(NUM_CH), .CH_W(CH_W)) u_steer (
        .vci (sop_vci),
        .cls (cls),
        .ch  (ch)
    );

    rxfb_chan_table #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we),
        .wr_ch  (cfg_ch),
        .wr_big (cfg_big),
        .rd_ch  (ch),
        .rd_big (ch_big)
    );

    rxfb_ring_heads #(.RING_DEPTH(RING_DEPTH), .RING_AW(RING_AW)) u_heads (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .adv_ring (mem_ring),
        .head     (head)
    );

    rxfb_alloc_fsm #(.CH_W(CH_W), .RING_AW(RING_AW), .PTR_W(PTR_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sop_valid   (sop_valid),
        .cls         (cls),
        .ch          (ch),
        .ch_big      (ch_big),
        .head        (head),
        .sop_ready   (sop_ready),
        .mem_req     (mem_req),
        .mem_ring    (mem_ring),
        .mem_idx     (mem_idx),
        .mem_rvalid  (mem_rvalid),
        .mem_own     (mem_own),
        .mem_ptr     (mem_ptr),
        .mem_clr     (mem_clr),
        .adv         (adv),
        .alloc_valid (alloc_valid),
        .alloc_ptr   (alloc_ptr),
        .alloc_ch    (alloc_ch),
        .nobuf       (nobuf),
        .oam_valid   (oam_valid),
        .bad_vci     (bad_vci)
    );

    assign alloc_big = mem_ring;

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (sop_ready && !mem_req && !mem_clr && !alloc_valid && !nobuf)); // R1
    AST_HEAD_HOLD_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        nobuf |-> $stable(head)); // R6
endmodule

// File: tb/rx_fbuf_alloc_tb.sv
// Bench: scoreboard driven. The driver task predicts each outcome from its own
// ring model; the monitor pops and compares on every result pulse.
module rx_fbuf_alloc_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [9:0]  cfg_ch = '0;
    logic        cfg_big = 1'b0;
    logic        sop_valid = 1'b0;
    logic [11:0] sop_vci = '0;
    logic        sop_ready, mem_req, mem_ring, mem_clr;
    logic [2:0]  mem_idx;
    logic        mem_rvalid = 1'b0, mem_own = 1'b0;
    logic [31:0] mem_ptr = '0;
    logic        alloc_valid, alloc_big, nobuf, oam_valid, bad_vci;
    logic [31:0] alloc_ptr;
    logic [9:0]  alloc_ch;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_fbuf_alloc u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_big(cfg_big),
        .sop_valid(sop_valid), .sop_vci(sop_vci), .sop_ready(sop_ready),
        .mem_req(mem_req), .mem_ring(mem_ring), .mem_idx(mem_idx),
        .mem_rvalid(mem_rvalid), .mem_own(mem_own), .mem_ptr(mem_ptr), .mem_clr(mem_clr),
        .alloc_valid(alloc_valid), .alloc_ptr(alloc_ptr), .alloc_big(alloc_big),
        .alloc_ch(alloc_ch), .nobuf(nobuf), .oam_valid(oam_valid), .bad_vci(bad_vci)
    );

    // Host memory model: ownership bit and pointer per entry, 1-cycle read latency.
    logic        own_m [2][DEPTH];
    logic [31:0] buf_m [2][DEPTH];
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_req) begin
            mem_rvalid <= 1'b1;
            mem_own    <= own_m[mem_ring][mem_idx];
            mem_ptr    <= buf_m[mem_ring][mem_idx];
        end
        if (mem_clr) own_m[mem_ring][mem_idx] <= 1'b0;
    end

    // Scoreboard state and independent reference model.
    typedef struct {
        int          kind;   // 0 alloc, 1 nobuf, 2 oam, 3 bad
        logic [31:0] ptr;
        int          ch;
        int          ring;
        int          idx;
        string       tag;
    } exp_t;
    exp_t q[$];
    int   checks = 0;
    int   failures = 0;
    int   head_m [2];
    logic sel_m [1024];

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic set_chan(input int ch, input bit big);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = 10'(ch); cfg_big = big;
        sel_m[ch] = big;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Driver: wait until ready, predict the outcome, and present one start of packet.
    task automatic send_sop(input int vci, input string tag);
        exp_t e;
        @(negedge clk);
        while (!sop_ready) @(negedge clk);
        e.tag = tag; e.ptr = '0; e.ch = vci % 1024; e.ring = 0; e.idx = 0;
        if (vci == 0) e.kind = 2;
        else if (vci >= 1024) e.kind = 3;
        else begin
            e.ring = int'(sel_m[vci]);
            e.idx  = head_m[e.ring];
            if (own_m[e.ring][e.idx]) begin
                e.kind = 0;
                e.ptr  = buf_m[e.ring][e.idx];
                head_m[e.ring] = (head_m[e.ring] + 1) % DEPTH;
            end else e.kind = 1;
        end
        q.push_back(e);
        sop_valid = 1'b1; sop_vci = 12'(vci);
        @(negedge clk);
        sop_valid = 1'b0;
    endtask

    // Monitor: pop and compare on every result pulse.
    always @(negedge clk) begin
        if (rst_n && (alloc_valid || nobuf || oam_valid || bad_vci)) begin
            int act;
            exp_t e;
            act = alloc_valid ? 0 : nobuf ? 1 : oam_valid ? 2 : 3;
            check($countones({alloc_valid, nobuf, oam_valid, bad_vci}) == 1, "R10",
                  "outcome pulses", {alloc_valid, nobuf, oam_valid, bad_vci}, 0);
            if (q.size() == 0) begin
                check(1'b0, "R9", "unexpected outcome", act, -1);
            end else begin
                e = q.pop_front();
                check(act == e.kind, e.tag, "outcome kind", act, e.kind);
                if (e.kind == 0) begin
                    check(alloc_ptr == e.ptr, e.tag, "alloc_ptr", alloc_ptr, e.ptr);
                    check(int'(alloc_big) == e.ring, e.tag, "alloc_big", alloc_big, e.ring);
                    check(int'(alloc_ch) == e.ch, e.tag, "alloc_ch", alloc_ch, e.ch);
                    check(mem_clr && int'(mem_ring) == e.ring && int'(mem_idx) == e.idx, "R4",
                          "returned entry {clr,ring,idx}", {mem_clr, mem_ring, mem_idx},
                          {1'b1, 1'(e.ring), 3'(e.idx)});
                end else if (e.kind == 1) begin
                    check(int'(alloc_ch) == e.ch, e.tag, "alloc_ch on drop", alloc_ch, e.ch);
                    check(!mem_clr, "R6", "mem_clr on drop", mem_clr, 0);
                end
            end
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", q.size(), 0);
        finish_run();
    end

    initial begin
        head_m[0] = 0; head_m[1] = 0;
        for (int i = 0; i < 1024; i++) sel_m[i] = 1'b0;
        for (int r = 0; r < 2; r++)
            for (int i = 0; i < DEPTH; i++) begin
                own_m[r][i] = 1'b1;
                buf_m[r][i] = 32'hA000_0000 | (r << 16) | (i << 6);
            end
        own_m[1][2] = 1'b0;                 // one host-held entry mid big ring
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset
        check(sop_ready == 1'b1, "R1", "sop_ready", sop_ready, 1);
        check({mem_req, mem_clr, alloc_valid, nobuf, oam_valid, bad_vci} == '0, "R1",
              "idle outputs", {mem_req, mem_clr, alloc_valid, nobuf, oam_valid, bad_vci}, 0);

        set_chan(5, 1'b1);
        set_chan(1023, 1'b1);
        send_sop(7, "R1");      // small head starts at 0
        send_sop(5, "R2");      // big ring, head 0
        send_sop(7, "R5");      // small ring index 1, big untouched
        send_sop(0, "R7");      // maintenance path
        send_sop(7, "R7");      // small index 2: OAM left head alone
        send_sop(1024, "R8");
        send_sop(4095, "R8");
        send_sop(1023, "R3");   // big index 1, last channel is data

        // R9: a second start of packet while a lookup is pending is ignored.
        send_sop(7, "R9");      // small index 3
        check(sop_ready == 1'b0, "R9", "sop_ready while pending", sop_ready, 0);
        sop_valid = 1'b1; sop_vci = 12'd0;
        @(negedge clk);
        sop_valid = 1'b0;

        send_sop(5, "R6");      // big index 2 is host-owned: drop
        @(negedge clk);
        while (!sop_ready) @(negedge clk);
        own_m[1][2] = 1'b1;
        buf_m[1][2] = 32'hB000_1234;
        send_sop(5, "R6");      // same entry now taken: head did not move

        for (int k = 4; k < DEPTH; k++) send_sop(7, "R5");
        send_sop(7, "R5");      // wrapped to small index 0, returned: drop
        @(negedge clk);
        while (!sop_ready) @(negedge clk);
        repeat (2) @(negedge clk);
        own_m[0][0] = 1'b1;
        buf_m[0][0] = 32'hC000_0040;
        send_sop(7, "R5");      // refilled index 0 after wrap

        repeat (6) @(negedge clk);
        check(q.size() == 0, "R10", "pending expectations", q.size(), 0);
        finish_run();
    end
endmodule